// File: doc/BRIEF.md
# Thread-Interleaved Architectural State

This block holds the architectural state of a core that runs several independent threads through one pipeline, one thread per clock slot in fixed rotation. Every storage element the original single-thread core had is replicated once per thread. That covers the general-purpose register file, the status register and the interrupt-vector register. A rotating slot counter names the thread that owns the current cycle. Register reads use that slot together with the register number. Write-backs and control-register writes carry their own thread ID, so a result can come back in a later slot than the one that produced it.

Memory requests from the pipeline leave the block tagged with the ID of the thread that issued them. Responses come back with a tag and are steered to the owning thread. A response whose tag names no configured thread raises an error flag. No arbitration and no bypassing happen between threads. With a thread count of one, the block reduces to ordinary single-thread state.

Top module: `mt_arch_state`

## Requirements
- R1: `cur_tid` is 0 during reset and advances by one on every clock after reset, wrapping from NUM_THREADS-1 back to 0; with NUM_THREADS=1 it stays 0.
- R2: Each thread owns NUM_REGS general-purpose registers, all zero after reset. `rs1_data` and `rs2_data` return entry `rs1_idx` / `rs2_idx` of thread `cur_tid`. A write-back (`wb_en`, `wb_tid`, `wb_idx`, `wb_data`) changes only entry `wb_idx` of thread `wb_tid`, from the next clock on.
- R3: A read in the same cycle as a write-back to the same register number returns the value held before that write. This holds whether the write belongs to another thread or to the reading thread; no bypass exists.
- R4: A write-back whose `wb_tid` is NUM_THREADS or greater changes no register of any thread.
- R5: After reset, every thread's status register reads 0 and thread t's interrupt vector reads IVEC_BASE + t*IVEC_STEP. `cur_status` and `cur_ivec` show the registers of thread `cur_tid`.
- R6: A control write (`csr_we`) updates the register of thread `csr_tid` selected by `csr_sel`, from the next clock on. `csr_sel`=0 selects status and takes the low STAT_W bits of `csr_wdata`; `csr_sel`=1 selects the interrupt vector. A `csr_tid` of NUM_THREADS or more changes nothing.
- R7: A request presented with `req_valid` appears one clock later on the `mreq_*` outputs with the same address, data and write flag. `mreq_tid` equals the `cur_tid` of the issuing cycle. Without `req_valid`, `mreq_valid` is 0 one clock later.
- R8: A response with `rsp_tid` below NUM_THREADS sets, one clock later, only bit `rsp_tid` of `rsp_hit`, with `rsp_data` equal to the response data, and `rsp_err` low.
- R9: A response with `rsp_tid` of NUM_THREADS or more sets `rsp_err` one clock later with `rsp_hit` all zero. Without `rsp_valid`, both are clear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_tid | output | 2 | Thread owning the current slot |
| rs1_idx | input | REG_W | First read register number |
| rs2_idx | input | REG_W | Second read register number |
| rs1_data | output | DATA_W | First read value for thread `cur_tid` |
| rs2_data | output | DATA_W | Second read value for thread `cur_tid` |
| wb_en | input | 1 | Write-back enable |
| wb_tid | input | 2 | Thread of the write-back |
| wb_idx | input | REG_W | Register number of the write-back |
| wb_data | input | DATA_W | Write-back value |
| csr_we | input | 1 | Control register write enable |
| csr_sel | input | 1 | 0 status, 1 interrupt vector |
| csr_tid | input | 2 | Thread of the control write |
| csr_wdata | input | VEC_W | Control write value |
| cur_status | output | STAT_W | Status register of thread `cur_tid` |
| cur_ivec | output | VEC_W | Interrupt vector of thread `cur_tid` |
| req_valid | input | 1 | Pipeline memory request valid |
| req_write | input | 1 | Request is a store |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| mreq_valid | output | 1 | Tagged request valid |
| mreq_write | output | 1 | Tagged request is a store |
| mreq_addr | output | ADDR_W | Tagged request address |
| mreq_wdata | output | DATA_W | Tagged store data |
| mreq_tid | output | 2 | Thread tag of the request |
| rsp_valid | input | 1 | Memory response valid |
| rsp_tid | input | 2 | Thread tag of the response |
| rsp_rdata | input | DATA_W | Response data |
| rsp_hit | output | NUM_THREADS | One-hot owner of the routed response |
| rsp_data | output | DATA_W | Routed response data |
| rsp_err | output | 1 | Response carried an unknown tag |

## Verification
The slot properties assume nothing about the inputs. The request and response properties assume that `req_*` and `rsp_*` are driven to known values whenever their valid is high. The stimulus meets this by driving every input from a known value at reset and changing inputs only between clock edges. Read checks pick the slot by a model counter kept in the bench. Out-of-range tags (3) are deliberately applied on the write-back, control and response paths to cover the rejection behaviour.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int MAX_THREADS = 3;
    localparam int TID_W       = 2;
    typedef logic [TID_W-1:0] tid_t;
    typedef enum logic {
        CSR_STATUS = 1'b0,
        CSR_IVEC   = 1'b1
    } csr_sel_e;
endpackage

// File: rtl/mt_slot_ctr.sv
module mt_slot_ctr
    import mt_pkg::*;
#(
    parameter int NUM_THREADS = 3
) (
    input  logic clk,
    input  logic rst_n,
    output tid_t slot_o
);
    localparam tid_t LAST = tid_t'(NUM_THREADS - 1);

    typedef struct packed {
        tid_t slot;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.slot == LAST) s_d.slot = '0;
        else                  s_d.slot = s_q.slot + tid_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_o = s_q.slot;
endmodule

// File: rtl/mt_gpr_bank.sv
module mt_gpr_bank
    import mt_pkg::*;
#(
    parameter int NUM_THREADS = 3,
    parameter int NUM_REGS    = 32,
    parameter int DATA_W      = 32,
    localparam int REG_W      = $clog2(NUM_REGS),
    localparam int IDX_W      = TID_W + REG_W,
    localparam int DEPTH      = NUM_THREADS * NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tid_t              rd_tid,
    input  logic [REG_W-1:0]  rd1_idx,
    input  logic [REG_W-1:0]  rd2_idx,
    output logic [DATA_W-1:0] rd1_data,
    output logic [DATA_W-1:0] rd2_data,
    input  logic              wr_en,
    input  tid_t              wr_tid,
    input  logic [REG_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0] waddr, raddr1, raddr2;
    logic             wr_ok;

    assign waddr  = {wr_tid, wr_idx};
    assign raddr1 = {rd_tid, rd1_idx};
    assign raddr2 = {rd_tid, rd2_idx};
    assign wr_ok  = wr_en && (int'(wr_tid) < NUM_THREADS);

    always_comb begin
        s_d = s_q;
        if (wr_ok) s_d.regs[int'(waddr)] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // reads see only state registered before this edge: no bypass
    assign rd1_data = s_q.regs[int'(raddr1)];
    assign rd2_data = s_q.regs[int'(raddr2)];
endmodule

// File: rtl/mt_csr_bank.sv
module mt_csr_bank
    import mt_pkg::*;
#(
    parameter int                NUM_THREADS = 3,
    parameter int                STAT_W      = 8,
    parameter int                VEC_W       = 32,
    parameter logic [VEC_W-1:0]  IVEC_BASE   = '0,
    parameter logic [VEC_W-1:0]  IVEC_STEP   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  csr_sel_e          wr_sel,
    input  tid_t              wr_tid,
    input  logic [VEC_W-1:0]  wr_data,
    input  tid_t              rd_tid,
    output logic [STAT_W-1:0] status_o,
    output logic [VEC_W-1:0]  ivec_o
);
    typedef struct packed {
        logic [NUM_THREADS-1:0][STAT_W-1:0] status;
        logic [NUM_THREADS-1:0][VEC_W-1:0]  ivec;
    } state_t;

    state_t s_d, s_q;

    function automatic state_t reset_value();
        state_t r;
        r = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            r.ivec[t] = IVEC_BASE + VEC_W'(t) * IVEC_STEP;
        end
        return r;
    endfunction

    always_comb begin
        s_d = s_q;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (wr_en && wr_tid == tid_t'(t)) begin
                if (wr_sel == CSR_STATUS) s_d.status[t] = wr_data[STAT_W-1:0];
                else                      s_d.ivec[t]   = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_value();
        else        s_q <= s_d;
    end

    always_comb begin
        status_o = '0;
        ivec_o   = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (rd_tid == tid_t'(t)) begin
                status_o = s_q.status[t];
                ivec_o   = s_q.ivec[t];
            end
        end
    end
endmodule

// File: rtl/mt_mem_tagger.sv
module mt_mem_tagger
    import mt_pkg::*;
#(
    parameter int NUM_THREADS = 3,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tid_t                   issue_tid,
    input  logic                   in_valid,
    input  logic                   in_write,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [DATA_W-1:0]      in_wdata,
    output logic                   out_valid,
    output logic                   out_write,
    output logic [ADDR_W-1:0]      out_addr,
    output logic [DATA_W-1:0]      out_wdata,
    output tid_t                   out_tid,
    input  logic                   back_valid,
    input  tid_t                   back_tid,
    input  logic [DATA_W-1:0]      back_data,
    output logic [NUM_THREADS-1:0] route_hit,
    output logic [DATA_W-1:0]      route_data,
    output logic                   route_err
);
    typedef struct packed {
        logic                   valid;
        logic                   write;
        logic [ADDR_W-1:0]      addr;
        logic [DATA_W-1:0]      wdata;
        tid_t                   tid;
        logic [NUM_THREADS-1:0] hit;
        logic [DATA_W-1:0]      rdata;
        logic                   err;
    } state_t;

    state_t s_d, s_q;
    logic   tag_known;

    assign tag_known = int'(back_tid) < NUM_THREADS;

    always_comb begin
        s_d       = s_q;
        s_d.valid = in_valid;
        if (in_valid) begin
            s_d.write = in_write;
            s_d.addr  = in_addr;
            s_d.wdata = in_wdata;
            s_d.tid   = issue_tid;
        end
        s_d.err = back_valid && !tag_known;
        for (int t = 0; t < NUM_THREADS; t++) begin
            s_d.hit[t] = back_valid && back_tid == tid_t'(t);
        end
        if (back_valid && tag_known) s_d.rdata = back_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid  = s_q.valid;
    assign out_write  = s_q.write;
    assign out_addr   = s_q.addr;
    assign out_wdata  = s_q.wdata;
    assign out_tid    = s_q.tid;
    assign route_hit  = s_q.hit;
    assign route_data = s_q.rdata;
    assign route_err  = s_q.err;
endmodule

// File: rtl/mt_arch_state.sv
module mt_arch_state
    import mt_pkg::*;
#(
    parameter int               NUM_THREADS = 3,
    parameter int               NUM_REGS    = 32,
    parameter int               DATA_W      = 32,
    parameter int               ADDR_W      = 32,
    parameter int               STAT_W      = 8,
    parameter int               VEC_W       = 32,
    parameter logic [VEC_W-1:0] IVEC_BASE   = 32'h0000_1000,
    parameter logic [VEC_W-1:0] IVEC_STEP   = 32'h0000_0100,
    localparam int              REG_W       = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [1:0]             cur_tid,
    input  logic [REG_W-1:0]       rs1_idx,
    input  logic [REG_W-1:0]       rs2_idx,
    output logic [DATA_W-1:0]      rs1_data,
    output logic [DATA_W-1:0]      rs2_data,
    input  logic                   wb_en,
    input  logic [1:0]             wb_tid,
    input  logic [REG_W-1:0]       wb_idx,
    input  logic [DATA_W-1:0]      wb_data,
    input  logic                   csr_we,
    input  logic                   csr_sel,
    input  logic [1:0]             csr_tid,
    input  logic [VEC_W-1:0]       csr_wdata,
    output logic [STAT_W-1:0]      cur_status,
    output logic [VEC_W-1:0]       cur_ivec,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   mreq_valid,
    output logic                   mreq_write,
    output logic [ADDR_W-1:0]      mreq_addr,
    output logic [DATA_W-1:0]      mreq_wdata,
    output logic [1:0]             mreq_tid,
    input  logic                   rsp_valid,
    input  logic [1:0]             rsp_tid,
    input  logic [DATA_W-1:0]      rsp_rdata,
    output logic [NUM_THREADS-1:0] rsp_hit,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_err
);
    tid_t slot;

    mt_slot_ctr #(.NUM_THREADS(NUM_THREADS)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot)
    );

    assign cur_tid = slot;

    mt_gpr_bank #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_REGS    (NUM_REGS),
        .DATA_W      (DATA_W)
    ) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_tid   (slot),
        .rd1_idx  (rs1_idx),
        .rd2_idx  (rs2_idx),
        .rd1_data (rs1_data),
        .rd2_data (rs2_data),
        .wr_en    (wb_en),
        .wr_tid   (wb_tid),
        .wr_idx   (wb_idx),
        .wr_data  (wb_data)
    );

    mt_csr_bank #(
        .NUM_THREADS (NUM_THREADS),
        .STAT_W      (STAT_W),
        .VEC_W       (VEC_W),
        .IVEC_BASE   (IVEC_BASE),
        .IVEC_STEP   (IVEC_STEP)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_we),
        .wr_sel   (csr_sel_e'(csr_sel)),
        .wr_tid   (csr_tid),
        .wr_data  (csr_wdata),
        .rd_tid   (slot),
        .status_o (cur_status),
        .ivec_o   (cur_ivec)
    );

    mt_mem_tagger #(
        .NUM_THREADS (NUM_THREADS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_tid  (slot),
        .in_valid   (req_valid),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .out_valid  (mreq_valid),
        .out_write  (mreq_write),
        .out_addr   (mreq_addr),
        .out_wdata  (mreq_wdata),
        .out_tid    (mreq_tid),
        .back_valid (rsp_valid),
        .back_tid   (rsp_tid),
        .back_data  (rsp_rdata),
        .route_hit  (rsp_hit),
        .route_data (rsp_data),
        .route_err  (rsp_err)
    );
endmodule

// File: rtl/mt_arch_state_chk.sv
module mt_arch_state_chk #(
    parameter int NUM_THREADS = 3,
    parameter int ADDR_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             cur_tid,
    input logic                   req_valid,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   mreq_valid,
    input logic [ADDR_W-1:0]      mreq_addr,
    input logic [1:0]             mreq_tid,
    input logic                   rsp_valid,
    input logic [1:0]             rsp_tid,
    input logic [NUM_THREADS-1:0] rsp_hit,
    input logic                   rsp_err
);
    assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_tid) < NUM_THREADS);

    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_tid) == NUM_THREADS - 1) |=> (cur_tid == 2'd0));

    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_tid) < NUM_THREADS - 1) |=> (cur_tid == $past(cur_tid) + 2'd1));

    assert_req_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (mreq_valid && mreq_tid == $past(cur_tid) && mreq_addr == $past(req_addr)));

    assert_req_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mreq_valid);

    assert_rsp_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && int'(rsp_tid) < NUM_THREADS)
        |=> (!rsp_err && rsp_hit == (NUM_THREADS'(1) << $past(rsp_tid))));

    assert_rsp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_hit));

    assert_rsp_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && int'(rsp_tid) >= NUM_THREADS) |=> (rsp_err && rsp_hit == '0));

    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> (!rsp_err && rsp_hit == '0));
endmodule

bind mt_arch_state mt_arch_state_chk #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_tid    (cur_tid),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .mreq_valid (mreq_valid),
    .mreq_addr  (mreq_addr),
    .mreq_tid   (mreq_tid),
    .rsp_valid  (rsp_valid),
    .rsp_tid    (rsp_tid),
    .rsp_hit    (rsp_hit),
    .rsp_err    (rsp_err)
);

// File: tb/mt_arch_state_bench.sv
module mt_arch_state_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          NT         = 3;
    localparam logic [31:0] BASE       = 32'h0000_1000;
    localparam logic [31:0] STEP       = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_tid;
    logic [4:0]  rs1_idx = '0, rs2_idx = '0;
    logic [31:0] rs1_data, rs2_data;
    logic        wb_en = 1'b0;
    logic [1:0]  wb_tid = '0;
    logic [4:0]  wb_idx = '0;
    logic [31:0] wb_data = '0;
    logic        csr_we = 1'b0, csr_sel = 1'b0;
    logic [1:0]  csr_tid = '0;
    logic [31:0] csr_wdata = '0;
    logic [7:0]  cur_status;
    logic [31:0] cur_ivec;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        mreq_valid, mreq_write;
    logic [31:0] mreq_addr, mreq_wdata;
    logic [1:0]  mreq_tid;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_tid = '0;
    logic [31:0] rsp_rdata = '0;
    logic [NT-1:0] rsp_hit;
    logic [31:0] rsp_data;
    logic        rsp_err;

    int total = 0;
    int bad   = 0;
    int m_slot = 0;
    bit finished = 1'b0;

    typedef struct { logic [1:0] tid; logic wr; logic [31:0] addr; logic [31:0] wdata; } req_item_t;
    typedef struct { logic [NT-1:0] hit; logic err; logic [31:0] data; } rsp_item_t;
    req_item_t req_q[$];
    rsp_item_t rsp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mt_arch_state u_mt_arch_state (.*);

    // independent slot model
    always @(posedge clk) begin
        if (!rst_n) m_slot <= 0;
        else        m_slot <= (m_slot + 1) % NT;
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wait_slot(int t);
        @(negedge clk);
        while (m_slot != t) @(negedge clk);
    endtask

    task automatic gpr_write(logic [1:0] t, logic [4:0] idx, logic [31:0] d);
        @(negedge clk);
        wb_en = 1'b1; wb_tid = t; wb_idx = idx; wb_data = d;
        @(negedge clk);
        wb_en = 1'b0;
    endtask

    task automatic issue(logic wr, logic [31:0] a, logic [31:0] d);
        req_item_t it;
        @(negedge clk);
        it.tid = 2'(m_slot); it.wr = wr; it.addr = a; it.wdata = d;
        req_q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    endtask

    task automatic respond(logic [1:0] t, logic [31:0] d);
        rsp_item_t it;
        @(negedge clk);
        it.err  = (int'(t) >= NT);
        it.hit  = it.err ? '0 : (NT'(1) << t);
        it.data = d;
        rsp_q.push_back(it);
        rsp_valid = 1'b1; rsp_tid = t; rsp_rdata = d;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mreq_valid) begin
                if (req_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R7 unexpected request got=%h exp=none", mreq_addr);
                end else begin
                    req_item_t e;
                    e = req_q.pop_front();
                    chk("R7 tag", 32'(mreq_tid), 32'(e.tid));
                    chk("R7 addr", mreq_addr, e.addr);
                    chk("R7 data", mreq_wdata, e.wdata);
                    chk("R7 write", 32'(mreq_write), 32'(e.wr));
                end
            end
            if (rsp_hit != '0 || rsp_err) begin
                if (rsp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R8 unexpected response got=%h exp=none", rsp_hit);
                end else begin
                    rsp_item_t e;
                    e = rsp_q.pop_front();
                    chk("R8 hit", 32'(rsp_hit), 32'(e.hit));
                    chk("R9 err", 32'(rsp_err), 32'(e.err));
                    if (!e.err) chk("R8 data", rsp_data, e.data);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r2v [NT];
        repeat (3) @(negedge clk);
        chk("R1 reset slot", 32'(cur_tid), 32'd0);
        chk("R2 reset read", rs1_data, 32'd0);
        rst_n = 1'b1;
        // R1: rotation
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk("R1 slot", 32'(cur_tid), 32'((k + 1) % NT));
        end
        // R5: reset values of control registers
        for (int t = 0; t < NT; t++) begin
            wait_slot(t);
            chk("R5 status", 32'(cur_status), 32'd0);
            chk("R5 ivec", cur_ivec, BASE + 32'(t) * STEP);
        end
        // R2: per-thread banks
        r2v[0] = 32'hA0A0_0001; r2v[1] = 32'hB1B1_0002; r2v[2] = 32'hC2C2_0003;
        for (int t = 0; t < NT; t++) gpr_write(2'(t), 5'd5, r2v[t]);
        rs1_idx = 5'd5; rs2_idx = 5'd6;
        for (int t = 0; t < NT; t++) begin
            wait_slot(t);
            chk("R2 rs1", rs1_data, r2v[t]);
            chk("R2 rs2 untouched", rs2_data, 32'd0);
        end
        rs2_idx = 5'd5;
        wait_slot(2);
        chk("R2 rs2", rs2_data, r2v[2]);
        // R3: other-thread write in the same cycle
        rs1_idx = 5'd7;
        wait_slot(0);
        wb_en = 1'b1; wb_tid = 2'd1; wb_idx = 5'd7; wb_data = 32'hDDDD_0007;
        #1 chk("R3 other thread", rs1_data, 32'd0);
        @(negedge clk); wb_en = 1'b0;
        chk("R3 visible next", rs1_data, 32'hDDDD_0007);
        wait_slot(0);
        chk("R3 owner only", rs1_data, 32'd0);
        // R3: same-thread write, same cycle
        wait_slot(1);
        wb_en = 1'b1; wb_tid = 2'd1; wb_idx = 5'd7; wb_data = 32'hEEEE_0007;
        #1 chk("R3 same thread", rs1_data, 32'hDDDD_0007);
        @(negedge clk); wb_en = 1'b0;
        wait_slot(1);
        chk("R3 after write", rs1_data, 32'hEEEE_0007);
        // R4: out-of-range write-back
        gpr_write(2'd3, 5'd9, 32'hFFFF_0009);
        rs1_idx = 5'd9;
        for (int t = 0; t < NT; t++) begin
            wait_slot(t);
            chk("R4 ignored", rs1_data, 32'd0);
        end
        // R6: control writes
        @(negedge clk);
        csr_we = 1'b1; csr_sel = 1'b0; csr_tid = 2'd1; csr_wdata = 32'h0000_005A;
        @(negedge clk);
        csr_sel = 1'b1; csr_tid = 2'd2; csr_wdata = 32'hABCD_0000;
        @(negedge clk);
        csr_sel = 1'b0; csr_tid = 2'd3; csr_wdata = 32'h0000_00FF;
        @(negedge clk);
        csr_we = 1'b0;
        wait_slot(0);
        chk("R6 t0 status", 32'(cur_status), 32'd0);
        chk("R6 t0 ivec", cur_ivec, BASE);
        wait_slot(1);
        chk("R6 t1 status", 32'(cur_status), 32'h5A);
        chk("R6 t1 ivec", cur_ivec, BASE + STEP);
        wait_slot(2);
        chk("R6 t2 status", 32'(cur_status), 32'd0);
        chk("R6 t2 ivec", cur_ivec, 32'hABCD_0000);
        // R7: tagged request burst across all slots
        for (int k = 0; k < 5; k++) issue(k[0], 32'h4000_0000 + 32'(k * 4), 32'h1111_0000 + 32'(k));
        @(negedge clk); req_valid = 1'b0;
        wait_slot(1);
        issue(1'b1, 32'h5000_0010, 32'h2222_2222);
        @(negedge clk); req_valid = 1'b0;
        // R8/R9: response routing including unknown tag
        respond(2'd0, 32'h3300_0000);
        respond(2'd2, 32'h3300_0002);
        respond(2'd3, 32'h3300_0003);
        respond(2'd1, 32'h3300_0001);
        @(negedge clk); rsp_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 queue drained", 32'(req_q.size()), 32'd0);
        chk("R9 queue drained", 32'(rsp_q.size()), 32'd0);
        chk("R9 quiet err", 32'(rsp_err), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule